// File: doc/BRIEF.md
# Error Record Transfer Engine

The engine moves one error record between an exchange buffer and one slot of a record storage RAM. Each record carries its own length, a little-endian 32-bit field, and its own identifier, a little-endian 64-bit field. The engine fetches both fields and checks the operation before it moves any data. A failed check ends the operation with a status code and leaves both RAMs untouched.

A store operation copies the record from the exchange buffer, starting at the given record offset, into byte 0 onward of the chosen slot. It then fills the rest of the slot with 0xFF. A load operation uses the length held in the stored record. It copies that many bytes from the slot into the exchange buffer, starting at the record offset.

A map controller outside the engine picks the slot and keeps track of identifiers. For a load, it supplies the slot index and a found flag together with the start pulse. For a store, the engine first shows the extracted identifier on `recId` with a one-cycle `idValid` strobe. The map controller answers in that same cycle with either a slot or a "no slot" indication. Data moves one byte per cycle. Both RAMs are single-port and have a one-cycle read latency.

Top module: `erte_top`

## Requirements
- R1: A store with all checks passing copies exchange bytes [offset, offset+len) into slot bytes [0, len) and returns status 0 (success).
- R2: After a successful store, slot bytes [len, REC_BYTES) hold 0xFF, and no other slot and no exchange byte changes.
- R3: A successful load copies slot bytes [0, len) into exchange bytes [offset, offset+len), where len is the length stored in that slot, returns status 0, and changes no other byte of either RAM.
- R4: The record length is read little-endian from record bytes 20..23. The identifier is read little-endian from record bytes 96..103.
- R5: A record offset above REC_BYTES-128 ends the operation with status 3 (failed). Neither RAM is written.
- R6: A length below 128, or above REC_BYTES minus the offset, with all 32 bits compared, gives status 3. Neither RAM is written.
- R7: A store whose identifier is 0 or all ones gives status 3. Neither RAM is written.
- R8: A valid store for which the map controller reports no slot (slotOk low while idValid is high) gives status 1 (not enough space). Neither RAM is written.
- R9: A load started with slotOk low gives status 5 (record not found). Neither RAM is written.
- R10: The checks have a fixed precedence. A store checks offset, then length, then identifier, then space. A load checks offset, then found, then length.
- R11: `busy` is high from the cycle after an accepted start until `done`. `done` is a one-cycle pulse that comes exactly one cycle after the last RAM write. A start pulse that arrives while busy is ignored.
- R12: During a store, `recId` carries the identifier taken from the record in the cycle that `idValid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startValid | input | 1 | Start pulse, accepted when idle |
| startWrite | input | 1 | 1 = store to slot, 0 = load from slot |
| recOffset | input | XAW+1 | Record byte offset in the exchange buffer |
| slotIdx | input | SIW | Slot chosen by the map controller |
| slotOk | input | 1 | Slot is valid (load: found; store: space) |
| recId | output | 64 | Identifier extracted from the record |
| idValid | output | 1 | Store only: slotIdx/slotOk sampled in this cycle |
| xAddr | output | XAW | Exchange RAM address |
| xRdData | input | 8 | Exchange RAM read data (one-cycle latency) |
| xWrEn | output | 1 | Exchange RAM write enable |
| xWrData | output | 8 | Exchange RAM write data |
| sAddr | output | XAW+SIW | Storage RAM address {slot, byte} |
| sRdData | input | 8 | Storage RAM read data (one-cycle latency) |
| sWrEn | output | 1 | Storage RAM write enable |
| sWrData | output | 8 | Storage RAM write data |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| status | output | 3 | Result: 0 ok, 1 no space, 3 failed, 5 not found |

## Verification
The bench sweeps offsets from 0 to the largest legal value and lengths from the minimum to the full remaining buffer, in every slot. After each operation it compares both RAMs in full against a model. If the engine had a length off by one, it would leave one byte stale or pad one byte too many. If it mixed up the byte order of a field, it would reject a legal length or accept an illegal one. The bench also probes each rejection one step past its limit: offset 129, length 127, length one past the buffer, a length with high bits set, and the two reserved identifiers. It combines failures to expose a wrong check order, where the wrong status code would come back. Finally, it checks that done lands exactly one cycle after the last write and that a start pulse during an operation does not disturb it.

// File: rtl/erte_pkg.sv
package erte_pkg;
  localparam int LEN_FIELD_AT = 20;
  localparam int ID_FIELD_AT = 96;

  typedef enum logic [2:0] {
    ST_OK        = 3'd0,
    ST_NO_SPACE  = 3'd1,
    ST_FAILED    = 3'd3,
    ST_NOT_FOUND = 3'd5
  } xferStatus_e;

  typedef struct packed {
    logic load;       // capture operation inputs
    logic slotLatch;  // capture slot for a store
    logic hdrRun;     // header field fetch
    logic copyRun;    // byte copy
  } xferCtl_t;
endpackage

// File: rtl/erte_datapath.sv
module erte_datapath import erte_pkg::*; #(
  parameter int REC_BYTES = 256,
  parameter int SLOTS = 4,
  parameter int MIN_LEN = 128,
  localparam int XAW = $clog2(REC_BYTES),
  localparam int SIW = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic            clk,
  input  logic            rstN,
  input  xferCtl_t        ctl,
  input  logic            startWrite,
  input  logic [XAW:0]    recOffset,
  input  logic [SIW-1:0]  slotIdx,
  input  logic [7:0]      xRdData,
  input  logic [7:0]      sRdData,
  output logic [XAW-1:0]  xAddr,
  output logic            xWrEn,
  output logic [7:0]      xWrData,
  output logic [XAW+SIW-1:0] sAddr,
  output logic            sWrEn,
  output logic [7:0]      sWrData,
  output logic [63:0]     recId,
  output logic            offBad,
  output logic            lenBad,
  output logic            idBad,
  output logic            hdrDone,
  output logic            copyLast
);
  localparam logic [XAW:0] OFF_MAX = (XAW+1)'(REC_BYTES - MIN_LEN);

  logic opWrite;
  logic [XAW:0] offQ;
  logic [SIW-1:0] slotQ;
  logic [3:0] hdrCnt, capIdx, idByteIdx, hdrNum;
  logic capValid;
  logic [31:0] lenQ;
  logic [63:0] idQ;
  logic [XAW:0] cnt, copyLen;
  logic wrPend, wrPad;
  logic [XAW-1:0] wrPos, hdrByte, xPos;
  logic [XAW:0] xSum;
  logic [7:0] capByte;

  assign hdrNum = opWrite ? 4'd12 : 4'd4;
  assign idByteIdx = capIdx - 4'd4;
  assign capByte = opWrite ? xRdData : sRdData;

  always_comb begin
    if (hdrCnt < 4'd4) hdrByte = XAW'(LEN_FIELD_AT) + XAW'(hdrCnt);
    else               hdrByte = XAW'(ID_FIELD_AT - 4) + XAW'(hdrCnt);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opWrite <= 1'b0; offQ <= '0; slotQ <= '0;
      hdrCnt <= '0; capIdx <= '0; capValid <= 1'b0;
      lenQ <= '0; idQ <= '0; cnt <= '0;
      wrPend <= 1'b0; wrPad <= 1'b0; wrPos <= '0;
    end else begin
      if (ctl.load) begin
        opWrite <= startWrite;
        offQ <= recOffset;
        slotQ <= slotIdx;
        hdrCnt <= '0;
        capValid <= 1'b0;
        lenQ <= '0;
        idQ <= '0;
        cnt <= '0;
      end else begin
        if (ctl.slotLatch) slotQ <= slotIdx;
        capValid <= ctl.hdrRun && (hdrCnt < hdrNum);
        capIdx <= hdrCnt;
        if (ctl.hdrRun && (hdrCnt < hdrNum)) hdrCnt <= hdrCnt + 4'd1;
        if (capValid) begin
          if (capIdx < 4'd4) lenQ[{capIdx[1:0], 3'b000} +: 8] <= capByte;
          else               idQ[{idByteIdx[2:0], 3'b000} +: 8] <= capByte;
        end
        if (ctl.copyRun) cnt <= cnt + 1'b1;
      end
      wrPend <= ctl.copyRun;
      wrPos <= cnt[XAW-1:0];
      wrPad <= opWrite && (32'(cnt) >= lenQ);
    end
  end

  assign hdrDone = capValid && (capIdx == hdrNum - 4'd1);
  assign offBad = recOffset > OFF_MAX;
  assign lenBad = (lenQ < 32'(MIN_LEN)) || (lenQ > (32'(REC_BYTES) - 32'(offQ)));
  assign idBad = (idQ == 64'd0) || (&idQ);
  assign recId = idQ;

  assign copyLen = opWrite ? (XAW+1)'(REC_BYTES) : lenQ[XAW:0];
  assign copyLast = ctl.copyRun && (cnt == copyLen - 1'b1);

  // exchange side: reads header/data for a store, is written for a load
  always_comb begin
    if (opWrite) xPos = ctl.copyRun ? cnt[XAW-1:0] : hdrByte;
    else         xPos = wrPos;
  end
  assign xSum = offQ + {1'b0, xPos};
  assign xAddr = xSum[XAW-1:0];
  assign xWrEn = wrPend && !opWrite;
  assign xWrData = sRdData;

  // storage side: {slot, byte}
  always_comb begin
    if (opWrite) sAddr = {slotQ, wrPos};
    else         sAddr = {slotQ, ctl.copyRun ? cnt[XAW-1:0] : hdrByte};
  end
  assign sWrEn = wrPend && opWrite;
  assign sWrData = wrPad ? 8'hFF : xRdData;

  a_r1_store_contiguous: assert property (@(posedge clk) disable iff (!rstN)
    (sWrEn && $past(sWrEn)) |-> (sAddr == $past(sAddr) + (XAW+SIW)'(1)));
  a_r3_load_contiguous: assert property (@(posedge clk) disable iff (!rstN)
    (xWrEn && $past(xWrEn)) |-> (xAddr == $past(xAddr) + XAW'(1)));
  a_r2_one_direction: assert property (@(posedge clk) disable iff (!rstN)
    !(sWrEn && xWrEn));
endmodule

// File: rtl/erte_control.sv
module erte_control import erte_pkg::*; (
  input  logic        clk,
  input  logic        rstN,
  input  logic        startValid,
  input  logic        startWrite,
  input  logic        slotOk,
  input  logic        offBad,
  input  logic        hdrDone,
  input  logic        lenBad,
  input  logic        idBad,
  input  logic        copyLast,
  output xferCtl_t    ctl,
  output logic        busy,
  output logic        done,
  output logic        idValid,
  output xferStatus_e status
);
  typedef enum logic [2:0] {S_IDLE, S_HDR, S_CHECK, S_COPY, S_DRAIN, S_FIN} state_e;

  state_e state, stateNext;
  xferStatus_e statusQ, statusNext;
  logic writeQ;

  always_comb begin
    stateNext = state;
    statusNext = statusQ;
    ctl = '0;
    case (state)
      S_IDLE: begin
        ctl.load = startValid;
        if (startValid) begin
          if (offBad) begin
            stateNext = S_FIN; statusNext = ST_FAILED;
          end else if (!startWrite && !slotOk) begin
            stateNext = S_FIN; statusNext = ST_NOT_FOUND;
          end else begin
            stateNext = S_HDR;
          end
        end
      end
      S_HDR: begin
        ctl.hdrRun = 1'b1;
        if (hdrDone) stateNext = S_CHECK;
      end
      S_CHECK: begin
        ctl.slotLatch = writeQ;
        if (lenBad || (writeQ && idBad)) begin
          stateNext = S_FIN; statusNext = ST_FAILED;
        end else if (writeQ && !slotOk) begin
          stateNext = S_FIN; statusNext = ST_NO_SPACE;
        end else begin
          stateNext = S_COPY;
        end
      end
      S_COPY: begin
        ctl.copyRun = 1'b1;
        if (copyLast) stateNext = S_DRAIN;
      end
      S_DRAIN: begin
        stateNext = S_FIN; statusNext = ST_OK;
      end
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      statusQ <= ST_OK;
      writeQ <= 1'b0;
    end else begin
      state <= stateNext;
      statusQ <= statusNext;
      if (ctl.load) writeQ <= startWrite;
    end
  end

  assign busy = (state != S_IDLE);
  assign done = (state == S_FIN);
  assign idValid = (state == S_CHECK) && writeQ;
  assign status = statusQ;

  a_r11_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  a_r11_start_accepted: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && startValid) |=> busy);
  a_r10_fail_skips_copy: assert property (@(posedge clk) disable iff (!rstN)
    (done && statusQ != ST_OK) |-> $past(state) != S_DRAIN);
endmodule

// File: rtl/erte_top.sv
module erte_top import erte_pkg::*; #(
  parameter int REC_BYTES = 256,
  parameter int SLOTS = 4,
  parameter int MIN_LEN = 128,
  localparam int XAW = $clog2(REC_BYTES),
  localparam int SIW = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               startValid,
  input  logic               startWrite,
  input  logic [XAW:0]       recOffset,
  input  logic [SIW-1:0]     slotIdx,
  input  logic               slotOk,
  output logic [63:0]        recId,
  output logic               idValid,
  output logic [XAW-1:0]     xAddr,
  input  logic [7:0]         xRdData,
  output logic               xWrEn,
  output logic [7:0]         xWrData,
  output logic [XAW+SIW-1:0] sAddr,
  input  logic [7:0]         sRdData,
  output logic               sWrEn,
  output logic [7:0]         sWrData,
  output logic               busy,
  output logic               done,
  output logic [2:0]         status
);
  xferCtl_t ctl;
  xferStatus_e statusE;
  logic offBad, lenBad, idBad, hdrDone, copyLast;

  erte_control u_control (
    .clk, .rstN, .startValid, .startWrite, .slotOk,
    .offBad, .hdrDone, .lenBad, .idBad, .copyLast,
    .ctl, .busy, .done, .idValid, .status(statusE)
  );

  erte_datapath #(.REC_BYTES(REC_BYTES), .SLOTS(SLOTS), .MIN_LEN(MIN_LEN)) u_datapath (
    .clk, .rstN, .ctl, .startWrite, .recOffset, .slotIdx,
    .xRdData, .sRdData, .xAddr, .xWrEn, .xWrData,
    .sAddr, .sWrEn, .sWrData, .recId,
    .offBad, .lenBad, .idBad, .hdrDone, .copyLast
  );

  assign status = statusE;

  a_r11_done_after_last_write: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sWrEn || xWrEn) |-> done);
  a_r11_quiet_when_idle: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !(sWrEn || xWrEn));
endmodule

// File: tb/erte_top_bench.sv
module erte_top_bench;
  localparam int REC = 256;
  localparam int SLOTS = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startValid = 1'b0, startWrite = 1'b0, slotOk = 1'b0;
  logic [8:0] recOffset = '0;
  logic [1:0] slotIdx = '0;
  logic [63:0] recId;
  logic idValid, xWrEn, sWrEn, busy, done;
  logic [7:0] xAddr, xWrData, sWrData;
  logic [7:0] xRdData, sRdData;
  logic [9:0] sAddr;
  logic [2:0] status;

  logic [7:0] xMem [0:REC-1];
  logic [7:0] sMem [0:REC*SLOTS-1];
  logic [7:0] expX [0:REC-1];
  logic [7:0] expS [0:REC*SLOTS-1];

  int nChecks = 0, nFail = 0;

  always #4 clk = ~clk;

  erte_top u_erte_top (
    .clk, .rstN, .startValid, .startWrite, .recOffset, .slotIdx, .slotOk,
    .recId, .idValid, .xAddr, .xRdData, .xWrEn, .xWrData,
    .sAddr, .sRdData, .sWrEn, .sWrData, .busy, .done, .status
  );

  always @(posedge clk) begin
    xRdData <= xMem[xAddr];
    if (xWrEn) xMem[xAddr] <= xWrData;
    sRdData <= sMem[sAddr];
    if (sWrEn) sMem[sAddr] <= sWrData;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic runOp(input bit wr, input int off, input int slot, input bit ok,
                       input longint len, input logic [63:0] id, input int seed,
                       input bit midStart, input string req);
    int expSt, cyc, lastWr, bad;
    bit anyWr, gotId;
    logic [63:0] idSeen;
    logic [31:0] len32;
    len32 = len[31:0];
    for (int i = 0; i < REC; i++) xMem[i] = 8'((i * 7 + seed) ^ 8'h5A);
    for (int i = 0; i < REC*SLOTS; i++) sMem[i] = 8'((i * 13 + seed * 3) ^ 8'hC3);
    if (wr && off + 103 < REC) begin
      for (int b = 0; b < 4; b++) xMem[off + 20 + b] = len32[8*b +: 8];
      for (int b = 0; b < 8; b++) xMem[off + 96 + b] = id[8*b +: 8];
    end
    if (!wr) for (int b = 0; b < 4; b++) sMem[slot*REC + 20 + b] = len32[8*b +: 8];
    for (int i = 0; i < REC; i++) expX[i] = xMem[i];
    for (int i = 0; i < REC*SLOTS; i++) expS[i] = sMem[i];
    // expected status from the check order
    if (off > REC - 128) expSt = 3;
    else if (wr) begin
      if (len32 < 128 || len32 > 32'(REC - off)) expSt = 3;
      else if (id == 64'd0 || &id) expSt = 3;
      else if (!ok) expSt = 1;
      else expSt = 0;
    end else begin
      if (!ok) expSt = 5;
      else if (len32 < 128 || len32 > 32'(REC - off)) expSt = 3;
      else expSt = 0;
    end
    if (expSt == 0) begin
      if (wr) for (int i = 0; i < REC; i++)
        expS[slot*REC + i] = (i < int'(len32)) ? xMem[off + i] : 8'hFF;
      else for (int i = 0; i < int'(len32); i++)
        expX[off + i] = sMem[slot*REC + i];
    end
    @(negedge clk);
    startValid = 1'b1; startWrite = wr; recOffset = 9'(off);
    slotIdx = 2'(slot); slotOk = ok;
    cyc = 0; lastWr = 0; anyWr = 0; gotId = 0; idSeen = '0;
    while (1) begin
      @(negedge clk);
      cyc++;
      if (cyc == 1) begin
        startValid = 1'b0;
        chk(busy == 1'b1, "R11", "busy after start", longint'(busy), 1);
      end
      if (midStart && cyc == 6) begin
        startValid = 1'b1; startWrite = !wr; recOffset = 9'd300;
      end
      if (midStart && cyc == 7) startValid = 1'b0;
      if (sWrEn || xWrEn) begin anyWr = 1; lastWr = cyc; end
      if (idValid) begin gotId = 1; idSeen = recId; end
      if (done) break;
      if (cyc > 3000) begin
        chk(0, req, "watchdog on operation", cyc, 0);
        break;
      end
    end
    chk(status == 3'(expSt), req, "status", longint'(status), expSt);
    if (anyWr) chk(cyc == lastWr + 1, "R11", "done after last write", cyc, lastWr + 1);
    if (expSt != 0) chk(!anyWr, req, "no write on reject", longint'(anyWr), 0);
    if (wr && gotId && off + 103 < REC)
      chk(idSeen == id, "R12", "identifier on recId", longint'(idSeen), longint'(id));
    bad = 0;
    for (int i = 0; i < REC; i++) if (xMem[i] !== expX[i]) bad++;
    chk(bad == 0, wr ? req : "R3", "exchange bytes wrong", bad, 0);
    bad = 0;
    for (int i = 0; i < REC*SLOTS; i++) if (sMem[i] !== expS[i]) bad++;
    chk(bad == 0, wr ? "R2" : req, "storage bytes wrong", bad, 0);
    @(negedge clk);
    chk(done == 1'b0 && busy == 1'b0, "R11", "done single pulse", longint'({busy, done}), 0);
  endtask

  initial begin
    #(8 * 190000);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

  initial begin
    int lens [3];
    int offs [4];
    for (int i = 0; i < REC; i++) xMem[i] = 8'h00;
    for (int i = 0; i < REC*SLOTS; i++) sMem[i] = 8'h00;
    repeat (3) @(negedge clk);
    chk(busy == 0 && done == 0, "R11", "reset busy/done", longint'({busy, done}), 0);
    chk(status == 3'd0, "R11", "reset status", longint'(status), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(!(sWrEn || xWrEn) && !busy, "R11", "idle after reset", longint'({sWrEn, xWrEn, busy}), 0);

    // R1 R2 R4: store sweep over offsets and lengths
    offs = '{0, 1, 77, 128};
    foreach (offs[k]) begin
      lens = '{128, 128 + (REC - offs[k] - 128) / 2, REC - offs[k]};
      foreach (lens[j])
        runOp(1, offs[k], (k + j) % SLOTS, 1, lens[j],
              64'h0123_4567_89AB_C000 + 64'(k * 3 + j), k * 5 + j, 0, "R1");
    end
    // R3 R4: load sweep
    offs = '{0, 64, 128, 100};
    foreach (offs[k]) begin
      lens = '{128, 128 + (REC - offs[k] - 128) / 3, REC - offs[k]};
      foreach (lens[j])
        runOp(0, offs[k], (k * 3 + j) % SLOTS, 1, lens[j], 64'd0, k + j * 7, 0, "R3");
    end
    // R5: offset bound
    runOp(1, 129, 0, 1, 128, 64'h55, 1, 0, "R5");
    runOp(0, 255, 1, 1, 128, 64'h0, 2, 0, "R5");
    runOp(1, 300, 2, 1, 128, 64'h55, 3, 0, "R5");
    runOp(1, 128, 2, 1, 128, 64'h56, 4, 0, "R5");
    // R6: length bounds, including upper bits
    runOp(1, 0, 1, 1, 127, 64'h77, 5, 0, "R6");
    runOp(1, 50, 1, 1, 207, 64'h77, 6, 0, "R6");
    runOp(1, 50, 1, 1, 206, 64'h78, 7, 0, "R6");
    runOp(1, 0, 1, 1, 64'h1000_0080, 64'h77, 8, 0, "R6");
    runOp(0, 0, 3, 1, 100, 64'h0, 9, 0, "R6");
    runOp(0, 64, 3, 1, 193, 64'h0, 10, 0, "R6");
    // R7: reserved identifiers
    runOp(1, 0, 0, 1, 200, 64'd0, 11, 0, "R7");
    runOp(1, 10, 0, 1, 200, 64'hFFFF_FFFF_FFFF_FFFF, 12, 0, "R7");
    runOp(1, 10, 0, 1, 200, 64'hFFFF_FFFF_FFFF_FFFE, 13, 0, "R7");
    // R8, R9
    runOp(1, 5, 2, 0, 160, 64'h1234, 14, 0, "R8");
    runOp(0, 5, 2, 0, 160, 64'h0, 15, 0, "R9");
    // R10: check order
    runOp(1, 0, 2, 0, 160, 64'd0, 16, 0, "R10");
    runOp(1, 0, 2, 0, 100, 64'd0, 17, 0, "R10");
    runOp(0, 200, 2, 0, 160, 64'h0, 18, 0, "R10");
    runOp(0, 0, 2, 0, 100, 64'h0, 19, 0, "R10");
    // R11: start while busy is ignored
    runOp(1, 3, 3, 1, 190, 64'hABCD, 20, 1, "R11");
    runOp(0, 7, 1, 1, 170, 64'h0, 21, 1, "R11");

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end
endmodule